// File: doc/BRIEF.md
# Dynamic Address Assignment Record Capture

This block listens to a decoded bus event stream from a two-wire serial bus monitor. The monitor supplies start and stop conditions, received bytes, acknowledge bits and write-parity bits, each as a one-cycle strobe. The block detects the broadcast command that opens dynamic address assignment. It then follows every assignment round. For each target it gathers the 48-bit provisioned identifier, the two characteristic bytes and the dynamic address byte, and emits them as one record.

A round opens with a START followed by the broadcast header. A target that acknowledges the header then sends eight bytes. After those bytes, the controller sends the address byte, which carries a parity bit. Once the acknowledge bit that follows the address byte has passed, the block publishes the new address so that a known-target table can store it. The procedure ends when no target acknowledges the header, when a STOP arrives, or when a round header does not carry the broadcast address.

Top module: `daa_capture`

## Requirements
- R1: After reset, `active_o`, `rec_valid_o`, `rec_par_err_o` and `kt_valid_o` are low and `rec_o` is zero.
- R2: The procedure is entered (`active_o` high from the cycle after the parity event) only after this exact sequence: a START, header byte 0xFC (broadcast address 0x7E, write), an ACK (`ev_nack_i`=0), command byte 0x07, and a parity bit that makes the command byte plus the bit hold an odd number of ones. For 0x07 that bit is 0.
- R3: A command byte other than 0x07, or a wrong parity bit after 0x07, leaves `active_o` low.
- R4: While the procedure is active, a START followed by a header whose bits 7:1 equal 0x7E and an ACK starts a record. The next eight bytes are captured as follows: byte 0 goes to `rec_o[71:64]` and byte 5 to `rec_o[31:24]`, so the identifier is most significant byte first. Byte 6 goes to `rec_o[23:16]` and byte 7 to `rec_o[15:8]`.
- R5: The ninth byte of a round is the address byte and goes to `rec_o[7:0]`. `rec_valid_o` pulses for exactly one cycle, in the cycle after that byte event.
- R6: `rec_par_err_o`, valid with `rec_valid_o`, is high when the address byte has an even number of ones.
- R7: On the acknowledge event that follows the address byte, `kt_valid_o` pulses for one cycle in the next cycle, with `kt_addr_o` equal to bits 7:1 of the address byte. The block then waits for the next round.
- R8: A NACK on a round header ends the procedure: `active_o` is low from the next cycle.
- R9: A STOP at any point of the procedure ends it. A partially received record is dropped and never produces `rec_valid_o`.
- R10: The byte buffer is cleared at the start of each round and after each address acknowledge. A second round's record depends only on its own bytes.
- R11: A round header whose bits 7:1 differ from 0x7E ends the procedure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start_i | input | 1 | START or repeated START seen |
| ev_stop_i | input | 1 | STOP seen |
| ev_byte_v_i | input | 1 | A full byte was received |
| ev_byte_i | input | 8 | Received byte, bit 7 first on the wire |
| ev_ack_v_i | input | 1 | Acknowledge bit seen |
| ev_nack_i | input | 1 | Acknowledge value, 1 = NACK |
| ev_par_v_i | input | 1 | Write-parity bit seen |
| ev_par_i | input | 1 | Write-parity bit value |
| active_o | output | 1 | Assignment procedure in progress |
| rec_valid_o | output | 1 | One-cycle record strobe |
| rec_o | output | 72 | Identifier, bus byte, device byte, address byte |
| rec_par_err_o | output | 1 | Address byte parity is wrong |
| kt_valid_o | output | 1 | One-cycle known-target strobe |
| kt_addr_o | output | 7 | Address added to the known-target set |

## Verification
The embedded assertions check, on every cycle, the following properties. Every record and known-target strobe is preceded by the matching byte or acknowledge event, and the two strobes never coincide. A STOP always returns the round sequencer to idle. The byte counter never shifts past the record length. Entry happens only while the sequencer is idle. Only the bench scenarios can show the rest: the byte ordering inside the record, the parity decision, entry rejection for a wrong command or parity, dropping a record that a STOP cuts short, and the independence of consecutive rounds.

// File: rtl/daa_cap_pkg.sv
package daa_cap_pkg;

  typedef enum logic [2:0] {
    E_IDLE, E_ADDR, E_ACK, E_CODE, E_PAR
  } entry_st_e;

  typedef enum logic [2:0] {
    R_OFF, R_WAIT, R_HDR, R_HACK, R_DATA, R_DADR, R_DACK
  } round_st_e;

  // 1 when the byte holds an odd number of ones
  function automatic logic odd_ones(input logic [7:0] b);
    return ^b;
  endfunction

  // parity bit that makes byte plus bit hold an odd count of ones
  function automatic logic par_bit_for(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/ccc_entry_detect.sv
module ccc_entry_detect
  import daa_cap_pkg::*;
#(
  parameter logic [6:0] BCAST      = 7'h7E,
  parameter logic [7:0] ENTRY_CODE = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_v_i,
  input  logic [7:0] byte_i,
  input  logic       ack_v_i,
  input  logic       nack_i,
  input  logic       par_v_i,
  input  logic       par_i,
  output logic       enter_o
);

  localparam logic [7:0] HDR_WR = {BCAST, 1'b0};
  localparam logic       EXP_PAR = par_bit_for(ENTRY_CODE);

  entry_st_e st, nxt;

  always_comb begin
    nxt     = st;
    enter_o = 1'b0;
    if (!enable_i || stop_i) begin
      nxt = E_IDLE;
    end else if (start_i) begin
      nxt = E_ADDR;
    end else begin
      case (st)
        E_ADDR: if (byte_v_i) nxt = (byte_i == HDR_WR) ? E_ACK : E_IDLE;
        E_ACK:  if (ack_v_i)  nxt = nack_i ? E_IDLE : E_CODE;
        E_CODE: if (byte_v_i) nxt = (byte_i == ENTRY_CODE) ? E_PAR : E_IDLE;
        E_PAR:  if (par_v_i) begin
                  enter_o = (par_i == EXP_PAR);
                  nxt     = E_IDLE;
                end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= E_IDLE;
    else        st <= nxt;

  // R2
  enter_needs_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> par_v_i);

endmodule

// File: rtl/rec_buffer.sv
module rec_buffer #(
  parameter int NBYTES = 8,
  localparam int CNT_W = $clog2(NBYTES + 1),
  localparam int DW    = NBYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic [7:0]       din_i,
  output logic [DW-1:0]    data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  // lane 0 holds the newest byte, lane NBYTES-1 the oldest
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [7:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       q <= '0;
        else if (clr_i)   q <= '0;
        else if (shift_i) q <= din_i;
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       q <= '0;
        else if (clr_i)   q <= '0;
        else if (shift_i) q <= g_lane[g-1].q;
    end
    assign data_o[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (shift_i) cnt_o <= cnt_o + 1'b1;

  assign last_o = (cnt_o == CNT_W'(NBYTES - 1));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i) |-> (cnt_o < CNT_W'(NBYTES)));

endmodule

// File: rtl/daa_round_fsm.sv
module daa_round_fsm
  import daa_cap_pkg::*;
#(
  parameter logic [6:0] BCAST = 7'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_v_i,
  input  logic [7:0] byte_i,
  input  logic       ack_v_i,
  input  logic       nack_i,
  input  logic       last_i,
  output logic       active_o,
  output logic       clr_o,
  output logic       shift_o,
  output logic       rec_fire_o,
  output logic       kt_fire_o
);

  round_st_e st, nxt;

  always_comb begin
    nxt        = st;
    clr_o      = 1'b0;
    shift_o    = 1'b0;
    rec_fire_o = 1'b0;
    kt_fire_o  = 1'b0;
    if (st != R_OFF && stop_i) begin
      nxt = R_OFF;
    end else if (st != R_OFF && start_i) begin
      nxt   = R_HDR;
      clr_o = 1'b1;
    end else begin
      case (st)
        R_OFF:  if (enter_i) nxt = R_WAIT;
        R_HDR:  if (byte_v_i) nxt = (byte_i[7:1] == BCAST) ? R_HACK : R_OFF;
        R_HACK: if (ack_v_i) begin
                  if (!nack_i) begin
                    nxt   = R_DATA;
                    clr_o = 1'b1;
                  end else begin
                    nxt = R_OFF;
                  end
                end
        R_DATA: if (byte_v_i) begin
                  shift_o = 1'b1;
                  if (last_i) nxt = R_DADR;
                end
        R_DADR: if (byte_v_i) begin
                  rec_fire_o = 1'b1;
                  nxt        = R_DACK;
                end
        R_DACK: if (ack_v_i) begin
                  kt_fire_o = 1'b1;
                  clr_o     = 1'b1;
                  nxt       = R_WAIT;
                end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= R_OFF;
    else        st <= nxt;

  assign active_o = (st != R_OFF);

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (st == R_OFF));

  // R2
  enter_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |-> (st == R_OFF));

  // R8
  nack_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R_HACK && ack_v_i && nack_i && !start_i && !stop_i) |=> !active_o);

endmodule

// File: rtl/daa_capture.sv
module daa_capture
  import daa_cap_pkg::*;
#(
  parameter int         ID_BYTES   = 6,
  parameter int         CHR_BYTES  = 2,
  parameter logic [6:0] BCAST      = 7'h7E,
  parameter logic [7:0] ENTRY_CODE = 8'h07,
  localparam int        REC_BYTES  = ID_BYTES + CHR_BYTES,
  localparam int        REC_W      = (REC_BYTES + 1) * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_i,
  input  logic             ev_stop_i,
  input  logic             ev_byte_v_i,
  input  logic [7:0]       ev_byte_i,
  input  logic             ev_ack_v_i,
  input  logic             ev_nack_i,
  input  logic             ev_par_v_i,
  input  logic             ev_par_i,
  output logic             active_o,
  output logic             rec_valid_o,
  output logic [REC_W-1:0] rec_o,
  output logic             rec_par_err_o,
  output logic             kt_valid_o,
  output logic [6:0]       kt_addr_o
);

  localparam int CNT_W = $clog2(REC_BYTES + 1);

  logic                   enter_w;
  logic                   clr_w, shift_w, rec_fire_w, kt_fire_w, last_w;
  logic [REC_BYTES*8-1:0] buf_w;
  logic [CNT_W-1:0]       cnt_w;
  logic [6:0]             addr_hold;

  ccc_entry_detect #(.BCAST(BCAST), .ENTRY_CODE(ENTRY_CODE)) u_entry (
    .clk(clk), .rst_n(rst_n), .enable_i(!active_o),
    .start_i(ev_start_i), .stop_i(ev_stop_i),
    .byte_v_i(ev_byte_v_i), .byte_i(ev_byte_i),
    .ack_v_i(ev_ack_v_i), .nack_i(ev_nack_i),
    .par_v_i(ev_par_v_i), .par_i(ev_par_i),
    .enter_o(enter_w)
  );

  daa_round_fsm #(.BCAST(BCAST)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_w),
    .start_i(ev_start_i), .stop_i(ev_stop_i),
    .byte_v_i(ev_byte_v_i), .byte_i(ev_byte_i),
    .ack_v_i(ev_ack_v_i), .nack_i(ev_nack_i), .last_i(last_w),
    .active_o(active_o), .clr_o(clr_w), .shift_o(shift_w),
    .rec_fire_o(rec_fire_w), .kt_fire_o(kt_fire_w)
  );

  rec_buffer #(.NBYTES(REC_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .shift_i(shift_w),
    .din_i(ev_byte_i), .data_o(buf_w), .cnt_o(cnt_w), .last_o(last_w)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_valid_o   <= 1'b0;
      rec_o         <= '0;
      rec_par_err_o <= 1'b0;
      addr_hold     <= '0;
      kt_valid_o    <= 1'b0;
      kt_addr_o     <= '0;
    end else begin
      rec_valid_o <= rec_fire_w;
      kt_valid_o  <= kt_fire_w;
      if (rec_fire_w) begin
        rec_o         <= {buf_w, ev_byte_i};
        rec_par_err_o <= !odd_ones(ev_byte_i);
        addr_hold     <= ev_byte_i[7:1];
      end
      if (kt_fire_w) kt_addr_o <= addr_hold;
    end

  // R5
  rec_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> $past(ev_byte_v_i));

  // R7
  kt_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kt_valid_o |-> $past(ev_ack_v_i));

  // R5
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid_o && kt_valid_o));

  // R10
  cnt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kt_valid_o |-> (cnt_w == '0));

endmodule

// File: tb/sim_daa_capture.sv
module sim_daa_capture;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start_i = 0, ev_stop_i = 0, ev_byte_v_i = 0;
  logic [7:0]  ev_byte_i = '0;
  logic        ev_ack_v_i = 0, ev_nack_i = 0, ev_par_v_i = 0, ev_par_i = 0;
  logic        active_o, rec_valid_o, rec_par_err_o, kt_valid_o;
  logic [71:0] rec_o;
  logic [6:0]  kt_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [71:0] exp_rec[$];
  logic        exp_perr[$];
  logic [6:0]  exp_kt[$];

  always #(PERIOD/2) clk = ~clk;

  daa_capture u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_start_i(ev_start_i), .ev_stop_i(ev_stop_i),
    .ev_byte_v_i(ev_byte_v_i), .ev_byte_i(ev_byte_i),
    .ev_ack_v_i(ev_ack_v_i), .ev_nack_i(ev_nack_i),
    .ev_par_v_i(ev_par_v_i), .ev_par_i(ev_par_i),
    .active_o(active_o), .rec_valid_o(rec_valid_o), .rec_o(rec_o),
    .rec_par_err_o(rec_par_err_o), .kt_valid_o(kt_valid_o), .kt_addr_o(kt_addr_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk) ev_start_i = 1; @(negedge clk) ev_start_i = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk) ev_stop_i = 1; @(negedge clk) ev_stop_i = 0;
  endtask
  task automatic ev_byte(input logic [7:0] d);
    @(negedge clk) ev_byte_v_i = 1; ev_byte_i = d;
    @(negedge clk) ev_byte_v_i = 0;
  endtask
  task automatic ev_ack(input logic n);
    @(negedge clk) ev_ack_v_i = 1; ev_nack_i = n;
    @(negedge clk) ev_ack_v_i = 0;
  endtask
  task automatic ev_par(input logic p);
    @(negedge clk) ev_par_v_i = 1; ev_par_i = p;
    @(negedge clk) ev_par_v_i = 0;
  endtask

  task automatic broadcast_cmd(input logic [7:0] code, input logic p);
    ev_start(); ev_byte(8'hFC); ev_ack(0); ev_byte(code); ev_par(p);
  endtask

  // one full round: expected record and known-target address pushed first
  task automatic round(input logic [47:0] pid, input logic [7:0] bcr,
                       input logic [7:0] dcr, input logic [7:0] ab);
    ev_start(); ev_byte(8'hFD); ev_ack(0);
    for (int i = 0; i < 6; i++) ev_byte(pid[47-8*i -: 8]);
    ev_byte(bcr); ev_byte(dcr);
    exp_rec.push_back({pid, bcr, dcr, ab});
    exp_perr.push_back(($countones(ab) % 2) == 0);
    exp_kt.push_back(ab[7:1]);
    ev_byte(ab);
    ev_ack(0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rec_valid_o) begin
        if (exp_rec.size() == 0) begin
          chk(0, "R9", "unexpected record", rec_o, '0);
        end else begin
          logic [71:0] er;
          logic        ep;
          er = exp_rec.pop_front();
          ep = exp_perr.pop_front();
          chk(rec_o == er, "R4", "record contents", rec_o, er);
          chk(rec_par_err_o == ep, "R6", "parity error flag", 72'(rec_par_err_o), 72'(ep));
        end
      end
      if (kt_valid_o) begin
        if (exp_kt.size() == 0) begin
          chk(0, "R7", "unexpected known-target strobe", 72'(kt_addr_o), '0);
        end else begin
          logic [6:0] ek;
          ek = exp_kt.pop_front();
          chk(kt_addr_o == ek, "R7", "known-target address", 72'(kt_addr_o), 72'(ek));
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    chk(active_o == 0, "R1", "active after reset", 72'(active_o), 0);
    chk(rec_valid_o == 0, "R1", "rec_valid after reset", 72'(rec_valid_o), 0);
    chk(kt_valid_o == 0, "R1", "kt_valid after reset", 72'(kt_valid_o), 0);
    chk(rec_par_err_o == 0, "R1", "par_err after reset", 72'(rec_par_err_o), 0);
    chk(rec_o == 0, "R1", "record after reset", rec_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 wrong command code
    broadcast_cmd(8'h06, 1'b1);
    chk(active_o == 0, "R3", "other code does not enter", 72'(active_o), 0);
    ev_stop();
    // R3 wrong parity for the entry code
    broadcast_cmd(8'h07, 1'b1);
    chk(active_o == 0, "R3", "bad parity does not enter", 72'(active_o), 0);
    ev_stop();

    // R2 proper entry
    broadcast_cmd(8'h07, 1'b0);
    chk(active_o == 1, "R2", "entry with good parity", 72'(active_o), 1);

    // R4 R5 R7 first target, odd-parity address 0x0B<<1|0 -> 0x16 has 3 ones
    round(48'h0123_4567_89AB, 8'h21, 8'hC5, 8'h16);
    chk(active_o == 1, "R7", "still active after round", 72'(active_o), 1);
    // R6 R10 second target with even-parity address byte 0x18
    round(48'hFEDC_BA98_7654, 8'h0F, 8'h3C, 8'h18);
    // third target, address 0x7F -> 0xFE has 7 ones
    round(48'h0000_0000_0001, 8'h80, 8'h01, 8'hFE);

    // R8 NACK on header ends the procedure
    ev_start(); ev_byte(8'hFD); ev_ack(1);
    chk(active_o == 0, "R8", "nack ends procedure", 72'(active_o), 0);
    ev_stop();

    // R9 STOP mid-record drops the partial record
    broadcast_cmd(8'h07, 1'b0);
    chk(active_o == 1, "R2", "re-entry", 72'(active_o), 1);
    ev_start(); ev_byte(8'hFD); ev_ack(0);
    ev_byte(8'h11); ev_byte(8'h22); ev_byte(8'h33);
    ev_stop();
    chk(active_o == 0, "R9", "stop ends procedure", 72'(active_o), 0);
    // bytes after the stop must not complete a record
    for (int i = 0; i < 6; i++) ev_byte(8'h44);
    chk(active_o == 0, "R9", "stays idle after stop", 72'(active_o), 0);

    // R11 non-broadcast header ends the procedure
    broadcast_cmd(8'h07, 1'b0);
    ev_start(); ev_byte(8'hA4);
    chk(active_o == 0, "R11", "other header ends procedure", 72'(active_o), 0);
    ev_stop();

    // R10 round after restart reuses a clean buffer
    broadcast_cmd(8'h07, 1'b0);
    ev_start(); ev_byte(8'hFD); ev_ack(0); ev_byte(8'hAA); ev_byte(8'hBB);
    round(48'h1111_2222_3333, 8'h44, 8'h55, 8'h2A);
    ev_stop();

    repeat (5) @(negedge clk);
    chk(exp_rec.size() == 0, "R5", "all records seen", 72'(exp_rec.size()), 0);
    chk(exp_kt.size() == 0, "R7", "all known-target strobes seen", 72'(exp_kt.size()), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule